// File: doc/BRIEF.md
# Variable-Precision Floating-Point Rounding Converter

This block narrows an IEEE binary32 operand into a smaller floating-point format whose shape is picked at run time. Three configuration inputs set the significand width (hidden bit included), the exponent width and the exponent bias. A two-bit mode input picks one of four rounding rules. The converter re-expresses the exponent against the new bias and cuts the significand down to the requested width. It then rounds the significand and folds any carry from the rounding back into the exponent. Results that leave the finite range become overflow or underflow. Zero, infinity and NaN inputs are carried through as the matching special encodings.

The result is right-aligned in a 32-bit word as sign, exponent and fraction. The word comes with three flags: inexact, overflow and underflow. A valid/ready handshake on each side surrounds one registered stage. A small two-state controller (EMPTY, FULL) manages that stage. The configuration and mode are sampled on the cycle an operand is accepted, so a change applies from the next accepted operand onward. Typical settings reproduce the common narrow formats: half precision (11/5/15), the 8-bit-significand brain format (8/8/127) and single precision unchanged (24/8/127).

Top module: `vpfp_round_conv`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1 until an operand is accepted.
- R2: The stage controller has two states. EMPTY moves to FULL on LOAD (`in_valid` and `in_ready`). FULL stays FULL on REFILL (a drain and an accept in the same cycle). FULL moves to EMPTY on DRAIN (a drain with no new operand). The result of an accepted operand is valid one clock later. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output word and the flags stay unchanged, even if the configuration changes.
- R3: The significand width `cfg_sig_w` is m and ranges from 3 to 24; values below 3 or above 24 are clamped to 3 or 24. The exponent width `cfg_exp_w` is e and ranges from 5 to 8, with out-of-range values clamped the same way. In the packed output the sign sits at bit m+e-1, the exponent takes bits m+e-2 down to m-1, the fraction takes bits m-2 down to 0, and all higher bits are zero.
- R4: For a normal input, the output exponent before rounding is input exponent − 127 + `cfg_bias`. With m=24, e=8 and bias 127, every finite non-zero normal input passes through bit for bit.
- R5: `rnd_mode` selects the rounding rule. 00 truncates toward zero. 01 rounds to nearest, with exact halves rounded up in magnitude. 10 rounds to nearest, with exact halves rounded to an even last bit. 11 rounds to odd: it forces the last kept bit to 1 whenever any discarded bit is non-zero. Mode 10 with 11/5/15 matches half-precision conversion for results in the normal range.
- R6: If rounding overflows the significand, the fraction becomes zero and the exponent increases by one.
- R7: An exponent above 2^e−2 (checked after any carry) is an overflow. Modes 00 and 11 then give the largest finite value (exponent 2^e−2, fraction all ones). Modes 01 and 10 give infinity. Overflow and inexact are both set.
- R8: A rebiased exponent below 1 gives a zero with the input's sign and sets underflow and inexact.
- R9: Zero and subnormal inputs give a zero with the input's sign and no flags.
- R10: An infinity input gives an all-ones exponent with a zero fraction. A NaN input gives an all-ones exponent with only the top fraction bit (bit m-2) set. The sign is kept and no flags are set.
- R11: For in-range normal results, inexact is 1 exactly when a discarded significand bit is non-zero. Overflow and underflow are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | 32 | binary32 operand |
| cfg_sig_w | input | 5 | Target significand width m including hidden bit |
| cfg_exp_w | input | 4 | Target exponent width e |
| cfg_bias | input | 8 | Target exponent bias |
| rnd_mode | input | 2 | Rounding rule select |
| out_valid | output | 1 | Result held in the stage |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Packed result, right-aligned |
| out_inexact | output | 1 | Result differs from the operand |
| out_overflow | output | 1 | Magnitude above the finite range |
| out_underflow | output | 1 | Magnitude below the normal range, flushed |

## Verification
Rounding carry and overflow can occur in the same cycle. When the kept significand is all ones and the discarded part rounds up, the carry pushes an exponent of 2^e−2 past the largest finite code. The bench triggers this with 65520.0 in half-precision shape. It expects infinity with overflow and inexact in both nearest modes, and the largest finite value with inexact only under truncation. A further half-precision run stalls the output, changes the configuration during the stall, and then performs a drain and a load in the same cycle. This checks that both results keep their own settings.

// File: rtl/vpfp_pkg.sv
package vpfp_pkg;
    localparam int SRC_W     = 32;
    localparam int SRC_EW    = 8;
    localparam int SRC_FW    = 23;
    localparam int SRC_BIAS  = 127;
    localparam int SIG_MAX   = SRC_FW + 1;
    localparam int SIG_MIN   = 3;
    localparam int EXP_MIN   = 5;
    localparam int EXP_MAX   = 8;
    localparam int SIGW_BITS = 5;
    localparam int EXPW_BITS = 4;
    localparam int BIAS_BITS = 8;
    localparam int EXPN_W    = SRC_EW + 3;

    typedef enum logic [1:0] {
        RM_TRUNC     = 2'b00,
        RM_NEAR_UP   = 2'b01,
        RM_NEAR_EVEN = 2'b10,
        RM_ODD       = 2'b11
    } rmode_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_t;

    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_NORM = 2'd1,
        CL_INF  = 2'd2,
        CL_NAN  = 2'd3
    } cls_t;

    typedef struct packed {
        logic                sign;
        cls_t                cls;
        logic [EXPN_W-1:0]   exp;
        logic [SIG_MAX-1:0]  sig;
    } unp_t;
endpackage

// File: rtl/vpfp_unpack.sv
module vpfp_unpack
    import vpfp_pkg::*;
(
    input  logic [SRC_W-1:0]     x_i,
    input  logic [BIAS_BITS-1:0] bias_i,
    output unp_t                 unp_o
);
    logic [SRC_EW-1:0] ex_field;
    logic [SRC_FW-1:0] fr_field;
    logic              ex_zero;
    logic              ex_ones;

    always_comb begin
        ex_field = x_i[SRC_W-2 -: SRC_EW];
        fr_field = x_i[SRC_FW-1:0];
        ex_zero  = (ex_field == '0);
        ex_ones  = (ex_field == '1);

        unp_o.sign = x_i[SRC_W-1];
        unp_o.sig  = {1'b1, fr_field};
        unp_o.exp  = EXPN_W'($signed(EXPN_W'(ex_field))
                             + $signed(EXPN_W'(bias_i))
                             - $signed(EXPN_W'(SRC_BIAS)));
        if (ex_zero)
            unp_o.cls = CL_ZERO;
        else if (ex_ones && fr_field == '0)
            unp_o.cls = CL_INF;
        else if (ex_ones)
            unp_o.cls = CL_NAN;
        else
            unp_o.cls = CL_NORM;
    end
endmodule

// File: rtl/vpfp_rounder.sv
module vpfp_rounder
    import vpfp_pkg::*;
#(
    parameter int SIG_W = SIG_MAX,
    parameter int CNT_W = SIGW_BITS
)(
    input  logic [SIG_W-1:0] sig_i,
    input  logic [CNT_W-1:0] keep_i,
    input  rmode_t           mode_i,
    output logic [SIG_W-2:0] frac_o,
    output logic             carry_o,
    output logic             inexact_o
);
    localparam int EXT_W = SIG_W + 1;
    localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

    logic [CNT_W-1:0] drop;
    logic [EXT_W-1:0] ext, mask_all, half_bit, rem, kept, sum, fmask, frac_full;
    logic             guard, sticky, bump;

    always_comb begin
        drop      = CNT_W'(SIG_W) - keep_i;
        ext       = {1'b0, sig_i};
        mask_all  = (ONE << drop) - ONE;
        half_bit  = (drop == '0) ? '0 : (ONE << (drop - CNT_W'(1)));
        rem       = ext & mask_all;
        kept      = ext >> drop;
        guard     = |(rem & half_bit);
        sticky    = |(rem & (mask_all >> 1));
        inexact_o = |rem;

        unique case (mode_i)
            RM_TRUNC:     bump = 1'b0;
            RM_NEAR_UP:   bump = guard;
            RM_NEAR_EVEN: bump = guard & (sticky | kept[0]);
            RM_ODD:       bump = 1'b0;
            default:      bump = 1'b0;
        endcase

        if (mode_i == RM_ODD)
            sum = kept | EXT_W'(inexact_o);
        else
            sum = kept + EXT_W'(bump);

        carry_o   = |(sum >> keep_i);
        fmask     = (ONE << (keep_i - CNT_W'(1))) - ONE;
        frac_full = carry_o ? '0 : (sum & fmask);
        frac_o    = frac_full[SIG_W-2:0];
    end
endmodule

// File: rtl/vpfp_pack.sv
module vpfp_pack
    import vpfp_pkg::*;
#(
    parameter int OUT_W = SRC_W,
    parameter int SIG_W = SIG_MAX,
    parameter int CNT_W = SIGW_BITS,
    parameter int EW_W  = EXPW_BITS
)(
    input  unp_t             unp_i,
    input  logic [SIG_W-2:0] frac_i,
    input  logic             carry_i,
    input  logic             inexact_i,
    input  logic [CNT_W-1:0] keep_i,
    input  logic [EW_W-1:0]  ew_i,
    input  rmode_t           mode_i,
    output logic [OUT_W-1:0] data_o,
    output logic             inx_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int POS_W = $clog2(OUT_W) + 1;

    logic [EXPN_W-1:0] all1, e_max, e_round, exp_f;
    logic [SIG_W-2:0]  frac_f, frac_ones, frac_nan;
    logic [POS_W-1:0]  pos_sign, pos_exp;
    logic              to_max;

    always_comb begin
        all1      = (EXPN_W'(1) << ew_i) - EXPN_W'(1);
        e_max     = all1 - EXPN_W'(1);
        e_round   = unp_i.exp + EXPN_W'(carry_i);
        frac_ones = (SIG_W-1)'(((EXPN_W+SIG_W)'(1) << (keep_i - CNT_W'(1))) - (EXPN_W+SIG_W)'(1));
        frac_nan  = (SIG_W-1)'((EXPN_W+SIG_W)'(1) << (keep_i - CNT_W'(2)));
        to_max    = (mode_i == RM_TRUNC) || (mode_i == RM_ODD);
        pos_exp   = POS_W'(keep_i) - POS_W'(1);
        pos_sign  = pos_exp + POS_W'(ew_i);

        exp_f  = '0;
        frac_f = '0;
        inx_o  = 1'b0;
        ovf_o  = 1'b0;
        unf_o  = 1'b0;

        unique case (unp_i.cls)
            CL_ZERO: begin
                exp_f  = '0;
                frac_f = '0;
            end
            CL_INF: begin
                exp_f  = all1;
                frac_f = '0;
            end
            CL_NAN: begin
                exp_f  = all1;
                frac_f = frac_nan;
            end
            CL_NORM: begin
                if ($signed(unp_i.exp) < $signed(EXPN_W'(1))) begin
                    unf_o = 1'b1;
                    inx_o = 1'b1;
                end else if ($signed(e_round) > $signed(e_max)) begin
                    ovf_o = 1'b1;
                    inx_o = 1'b1;
                    if (to_max) begin
                        exp_f  = e_max;
                        frac_f = frac_ones;
                    end else begin
                        exp_f  = all1;
                        frac_f = '0;
                    end
                end else begin
                    exp_f  = e_round;
                    frac_f = frac_i;
                    inx_o  = inexact_i;
                end
            end
            default: begin
                exp_f  = '0;
                frac_f = '0;
            end
        endcase

        data_o = (OUT_W'(unp_i.sign) << pos_sign)
               | (OUT_W'(exp_f) << pos_exp)
               | OUT_W'(frac_f);
    end
endmodule

// File: rtl/vpfp_round_conv.sv
module vpfp_round_conv
    import vpfp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [SRC_W-1:0]     in_data,
    input  logic [SIGW_BITS-1:0] cfg_sig_w,
    input  logic [EXPW_BITS-1:0] cfg_exp_w,
    input  logic [BIAS_BITS-1:0] cfg_bias,
    input  logic [1:0]           rnd_mode,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [SRC_W-1:0]     out_data,
    output logic                 out_inexact,
    output logic                 out_overflow,
    output logic                 out_underflow
);
    stage_t                 state_q, state_d;
    logic                   accept, drain;
    logic [SIGW_BITS-1:0]   keep_c;
    logic [EXPW_BITS-1:0]   ew_c;
    rmode_t                 mode_c;
    unp_t                   unp;
    logic [SIG_MAX-2:0]     frac_r;
    logic                   carry_r, inexact_r;
    logic [SRC_W-1:0]       data_c;
    logic                   inx_c, ovf_c, unf_c;

    // configuration clamping
    always_comb begin
        if (cfg_sig_w < SIGW_BITS'(SIG_MIN))
            keep_c = SIGW_BITS'(SIG_MIN);
        else if (cfg_sig_w > SIGW_BITS'(SIG_MAX))
            keep_c = SIGW_BITS'(SIG_MAX);
        else
            keep_c = cfg_sig_w;

        if (cfg_exp_w < EXPW_BITS'(EXP_MIN))
            ew_c = EXPW_BITS'(EXP_MIN);
        else if (cfg_exp_w > EXPW_BITS'(EXP_MAX))
            ew_c = EXPW_BITS'(EXP_MAX);
        else
            ew_c = cfg_exp_w;

        mode_c = rmode_t'(rnd_mode);
    end

    vpfp_unpack u_unpack (
        .x_i    (in_data),
        .bias_i (cfg_bias),
        .unp_o  (unp)
    );

    vpfp_rounder #(.SIG_W(SIG_MAX), .CNT_W(SIGW_BITS)) u_round (
        .sig_i     (unp.sig),
        .keep_i    (keep_c),
        .mode_i    (mode_c),
        .frac_o    (frac_r),
        .carry_o   (carry_r),
        .inexact_o (inexact_r)
    );

    vpfp_pack #(.OUT_W(SRC_W), .SIG_W(SIG_MAX), .CNT_W(SIGW_BITS), .EW_W(EXPW_BITS)) u_pack (
        .unp_i     (unp),
        .frac_i    (frac_r),
        .carry_i   (carry_r),
        .inexact_i (inexact_r),
        .keep_i    (keep_c),
        .ew_i      (ew_c),
        .mode_i    (mode_c),
        .data_o    (data_c),
        .inx_o     (inx_c),
        .ovf_o     (ovf_c),
        .unf_o     (unf_c)
    );

    // stage controller: next state
    always_comb begin
        accept  = in_valid && in_ready;
        drain   = out_valid && out_ready;
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;           // LOAD
            ST_FULL:  if (drain && !accept) state_d = ST_EMPTY; // DRAIN; REFILL stays
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // handshake outputs
    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data      <= '0;
            out_inexact   <= 1'b0;
            out_overflow  <= 1'b0;
            out_underflow <= 1'b0;
        end else if (accept) begin
            out_data      <= data_c;
            out_inexact   <= inx_c;
            out_overflow  <= ovf_c;
            out_underflow <= unf_c;
        end
    end
endmodule

// File: rtl/vpfp_checker.sv
module vpfp_checker
    import vpfp_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [SRC_W-1:0]     in_data,
    input logic [SIGW_BITS-1:0] cfg_sig_w,
    input logic [EXPW_BITS-1:0] cfg_exp_w,
    input logic [BIAS_BITS-1:0] cfg_bias,
    input logic [1:0]           rnd_mode,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [SRC_W-1:0]     out_data,
    input logic                 out_inexact,
    input logic                 out_overflow,
    input logic                 out_underflow
);
    // R2: a stalled result holds still
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_overflow) && $stable(out_underflow) && $stable(out_inexact));

    // R2: an accepted operand is presented on the next cycle
    a_r2_load_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R1: an empty stage always accepts
    a_r1_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R7: overflow implies inexact
    a_r7_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_overflow |-> out_inexact);

    // R8: underflow implies inexact
    a_r8_unf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_underflow |-> out_inexact);

    // R11: range flags are exclusive
    a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_overflow, out_underflow}));
endmodule

bind vpfp_round_conv vpfp_checker u_chk (.*);

// File: tb/sim_vpfp_round_conv.sv
`timescale 1ns/1ps
module sim_vpfp_round_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [4:0]  cfg_sig_w = 5'd11;
    logic [3:0]  cfg_exp_w = 4'd5;
    logic [7:0]  cfg_bias = 8'd15;
    logic [1:0]  rnd_mode = 2'b10;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_inexact, out_overflow, out_underflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vpfp_round_conv u0 (.*);

    task automatic chk(input string tag, input logic [34:0] got, input logic [34:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    // independent model: {inexact, overflow, underflow, data}
    function automatic logic [34:0] model(input logic [31:0] x, input int m_in, input int e_in,
                                          input int bias, input int mode);
        int mm, ee, ex, ne, sh;
        longint full, q, r, halfv, maxe;
        logic s;
        logic inx;
        mm = (m_in < 3) ? 3 : (m_in > 24) ? 24 : m_in;
        ee = (e_in < 5) ? 5 : (e_in > 8) ? 8 : e_in;
        s  = x[31];
        ex = int'(x[30:23]);
        maxe = (longint'(1) << ee) - 2;
        if (ex == 0) return {3'b000, 32'(longint'(s) << (mm+ee-1))};
        if (ex == 255) begin
            if (x[22:0] == 0)
                return {3'b000, 32'((longint'(s) << (mm+ee-1)) | ((maxe+1) << (mm-1)))};
            return {3'b000, 32'((longint'(s) << (mm+ee-1)) | ((maxe+1) << (mm-1))
                               | (longint'(1) << (mm-2)))};
        end
        ne = ex - 127 + bias;
        if (ne < 1) return {3'b101, 32'(longint'(s) << (mm+ee-1))};
        sh    = 24 - mm;
        full  = (longint'(1) << 23) | longint'(x[22:0]);
        q     = full >> sh;
        r     = full - (q << sh);
        halfv = (sh > 0) ? (longint'(1) << (sh-1)) : 0;
        inx   = (r != 0);
        case (mode)
            1: if (sh > 0 && r >= halfv) q++;
            2: if (sh > 0 && (r > halfv || (r == halfv && q[0]))) q++;
            3: if (inx) q = q | 1;
            default: ;
        endcase
        if (q == (longint'(1) << mm)) begin q = q >> 1; ne++; end
        if (ne > maxe) begin
            if (mode == 0 || mode == 3)
                return {3'b110, 32'((longint'(s) << (mm+ee-1)) | (maxe << (mm-1))
                                   | ((longint'(1) << (mm-1)) - 1))};
            return {3'b110, 32'((longint'(s) << (mm+ee-1)) | ((maxe+1) << (mm-1)))};
        end
        return {inx, 2'b00, 32'((longint'(s) << (mm+ee-1)) | (longint'(ne) << (mm-1))
                                | (q & ((longint'(1) << (mm-1)) - 1)))};
    endfunction

    task automatic xfer(input logic [31:0] x, input int m, input int e, input int b,
                        input int mode, output logic [34:0] res);
        @(negedge clk);
        in_data = x; cfg_sig_w = 5'(m); cfg_exp_w = 4'(e); cfg_bias = 8'(b);
        rnd_mode = 2'(mode); in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        res = {out_inexact, out_overflow, out_underflow, out_data};
    endtask

    task automatic run(input string tag, input logic [31:0] x, input int m, input int e,
                       input int b, input int mode, input logic [34:0] exp);
        logic [34:0] res;
        xfer(x, m, e, b, mode, res);
        chk(tag, res, exp);
    endtask

    task automatic t_reset;
        chk("R1 reset valid/ready", {33'd0, out_valid, in_ready}, {33'd0, 1'b0, 1'b1});
    endtask

    task automatic t_identity;
        run("R4 identity pi",  32'h40490FDB, 24, 8, 127, 2, {3'b000, 32'h40490FDB});
        run("R4 identity neg", 32'hC2F6E979, 24, 8, 127, 0, {3'b000, 32'hC2F6E979});
        run("R4 custom bias",  32'h3F800000, 11, 5, 20, 2, {3'b000, 32'h00005000});
    endtask

    task automatic t_modes;
        run("R5 half one",   32'h3F800000, 11, 5, 15, 2, {3'b000, 32'h00003C00});
        run("R5 tie RTZ",    32'h3F801000, 11, 5, 15, 0, {3'b100, 32'h00003C00});
        run("R5 tie near-up",32'h3F801000, 11, 5, 15, 1, {3'b100, 32'h00003C01});
        run("R5 tie even",   32'h3F801000, 11, 5, 15, 2, {3'b100, 32'h00003C00});
        run("R5 tie odd",    32'h3F801000, 11, 5, 15, 3, {3'b100, 32'h00003C01});
        run("R5 bf16 one",   32'h3F800000, 8, 8, 127, 2, {3'b000, 32'h00003F80});
        run("R5 bf16 pi",    32'h40490FDB, 8, 8, 127, 2, {3'b100, 32'h00004049});
    endtask

    task automatic t_carry;
        run("R6 carry even", 32'h3FFFF000, 11, 5, 15, 2, {3'b100, 32'h00004000});
        run("R6 no carry trunc", 32'h3FFFF000, 11, 5, 15, 0, {3'b100, 32'h00003FFF});
        run("R6 m3 carry",   32'h3FF00000, 3, 5, 15, 2, {3'b100, 32'h00000040});
        run("R3 m3 exact",   32'h3FE00000, 3, 5, 15, 0, {3'b000, 32'h0000003F});
    endtask

    task automatic t_overflow;
        run("R7 ovf even",   32'h47800000, 11, 5, 15, 2, {3'b110, 32'h00007C00});
        run("R7 ovf trunc",  32'h47800000, 11, 5, 15, 0, {3'b110, 32'h00007BFF});
        run("R7 ovf odd neg",32'hC7800000, 11, 5, 15, 3, {3'b110, 32'h0000FBFF});
        run("R7 carry into ovf", 32'h477FF000, 11, 5, 15, 2, {3'b110, 32'h00007C00});
        run("R7 carry into ovf up", 32'h477FF000, 11, 5, 15, 1, {3'b110, 32'h00007C00});
        run("R7 edge trunc no ovf", 32'h477FF000, 11, 5, 15, 0, {3'b100, 32'h00007BFF});
    endtask

    task automatic t_underflow;
        run("R8 unf pos", 32'h38000000, 11, 5, 15, 2, {3'b101, 32'h00000000});
        run("R8 unf neg", 32'hB8000000, 11, 5, 15, 2, {3'b101, 32'h00008000});
        run("R8 min normal", 32'h38800000, 11, 5, 15, 2, {3'b000, 32'h00000400});
    endtask

    task automatic t_zero_special;
        run("R9 pos zero",  32'h00000000, 11, 5, 15, 2, {3'b000, 32'h00000000});
        run("R9 neg zero",  32'h80000000, 11, 5, 15, 2, {3'b000, 32'h00008000});
        run("R9 subnormal", 32'h00400000, 11, 5, 15, 1, {3'b000, 32'h00000000});
        run("R10 inf",      32'h7F800000, 11, 5, 15, 2, {3'b000, 32'h00007C00});
        run("R10 neg inf",  32'hFF800000, 8, 8, 127, 0, {3'b000, 32'h0000FF80});
        run("R10 nan",      32'h7FC00001, 11, 5, 15, 2, {3'b000, 32'h00007E00});
        run("R10 nan m3",   32'hFF800001, 3, 6, 31, 2, {3'b000, 32'h000001FE});
    endtask

    task automatic t_clamp;
        run("R3 clamp hi", 32'h40490FDB, 31, 15, 127, 2, {3'b000, 32'h40490FDB});
        run("R3 clamp lo", 32'h3FE00000, 1, 2, 15, 0, {3'b000, 32'h0000003F});
    endtask

    task automatic t_inexact;
        run("R11 exact",   32'h3FC00000, 11, 5, 15, 2, {3'b000, 32'h00003E00});
        run("R11 sticky",  32'h3F800001, 11, 5, 15, 0, {3'b100, 32'h00003C00});
        run("R11 odd sticky", 32'h3F800001, 11, 5, 15, 3, {3'b100, 32'h00003C01});
    endtask

    task automatic t_handshake;
        @(negedge clk);
        out_ready = 1'b0;
        in_data = 32'h3F800000; cfg_sig_w = 5'd11; cfg_exp_w = 4'd5; cfg_bias = 8'd15;
        rnd_mode = 2'b10; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 load next", {33'd0, out_valid, in_ready}, {33'd0, 1'b1, 1'b0});
        in_data = 32'h40000000; cfg_sig_w = 5'd8; cfg_exp_w = 4'd8; cfg_bias = 8'd127;
        @(posedge clk); @(negedge clk);
        chk("R2 stall hold", {out_inexact, out_overflow, out_underflow, out_data},
            {3'b000, 32'h00003C00});
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk("R2 refill data", {out_inexact, out_overflow, out_underflow, out_data},
            {3'b000, 32'h00004000});
        chk("R2 refill valid", {34'd0, out_valid}, {34'd0, 1'b1});
        @(posedge clk); @(negedge clk);
        chk("R2 drain", {33'd0, out_valid, in_ready}, {33'd0, 1'b0, 1'b1});
    endtask

    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] x;
            int m, e, b, md;
            m  = 3 + int'($urandom_range(21));
            e  = 5 + int'($urandom_range(3));
            b  = (1 << (e-1)) - 1 + int'($urandom_range(6)) - 3;
            md = int'($urandom_range(3));
            x  = {1'($urandom), 8'(110 + $urandom_range(36)), 23'($urandom)};
            run("R5 sweep", x, m, e, b, md, model(x, m, e, b, md));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_modes();
        t_carry();
        t_overflow();
        t_underflow();
        t_zero_special();
        t_clamp();
        t_inexact();
        t_handshake();
        t_random();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule